// File: doc/BRIEF.md
# SPI NAND Page Program and Block Erase Sequencer

This block drives the byte-level command flow for one program or one erase on a serial NAND device. After a start strobe it latches the selected operation and its arguments. It then issues the command frames in order through a byte shifter, which is a separate block. The shifter handles clock and line timing. This block decides which byte goes out, when chip select frames it, and how to read the device's answer.

Both operations end with repeated status reads until the device reports that it is idle.
- **Program:** the engine loads the page cache with a byte range taken from a ready/valid source, sets the write latch, then commits the page.
- **Erase:** the engine sets the write latch, then erases one 128 KiB block, which is 64 pages of 2048 bytes.

The last status byte gives the pass/fail verdict. The engine reads a different status bit for each operation. One page per run is handled. A higher layer splits longer transfers into pages.

Top module: `spinand_pe_engine`

## Requirements
- R1: After reset, `spi_cs_o`, `spi_req_o`, `src_ready_o`, `busy_o`, `done_o` and `fail_o` are all 0.
- R2: A program run starts with one chip-select frame: byte 0x02, then the column `addr_i[10:0]` as a 16-bit value with the high byte first, then exactly `len_i` source bytes. There is no dummy byte.
- R3: During the source-data part of the load frame, `spi_req_o` is low while `src_valid_i` is low, and chip select stays asserted. `src_ready_o` is high only in a cycle where the shifter acknowledges a data byte.
- R4: A single-byte frame 0x06 comes after the load frame in a program run. It is the first frame in an erase run.
- R5: In a program run, the frame after 0x06 is 0x10 followed by the 24-bit row `addr_i >> 11`, high byte first.
- R6: In an erase run, the frame after 0x06 is 0xD8 followed by the 24-bit row `blk_i << 6`, high byte first.
- R7: Each status read is the frame 0x0F, 0xC0, 0x00. The byte received with the third byte is the status. If its bit 0 is 1, a new status read follows.
- R8: When a status read returns bit 0 = 0, `done_o` pulses high for exactly one cycle. `fail_o` then holds status bit 3 for a program run (`op_erase_i` = 0) or status bit 2 for an erase run (`op_erase_i` = 1).
- R9: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. A start strobe while `busy_o` is high is ignored: the running operation, its bytes and its verdict do not change, and no second run follows.
- R10: `spi_req_o` is only high while `spi_cs_o` is high. After the last byte of a frame is acknowledged, chip select drops for exactly one cycle before the next frame.
- R11: `fail_o` keeps its value until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| op_erase_i | input | 1 | 0 = program, 1 = block erase |
| addr_i | input | ADDR_W | Byte address for a program run |
| blk_i | input | BLK_W | Block index for an erase run |
| len_i | input | LEN_W | Number of data bytes for a program run |
| src_data_i | input | 8 | Source byte |
| src_valid_i | input | 1 | Source byte valid |
| src_ready_o | output | 1 | Source byte consumed |
| spi_cs_o | output | 1 | Chip select, active high |
| spi_req_o | output | 1 | Byte transfer request to the shifter |
| spi_tx_o | output | 8 | Byte to shift out |
| spi_ack_i | input | 1 | Shifter finished the requested byte |
| spi_rx_i | input | 8 | Byte received during the acknowledged transfer |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Verdict of the last completed operation |

## Verification
The bench runs a behavioural model against every output cycle by cycle. The shifter acknowledges at random points and the source drops valid at random points.

The corner cases it targets:
- **Swapped verdict bits:** each run's status sets the other operation's fail bit. A design that used the wrong bit would report a failure on a clean run.
- **Column edges:** a program run at the last column of a page and a run on a page boundary. A wrong column width or an off-by-one in the data count would send a wrong byte or a frame of the wrong length.
- **Start while busy:** a start with different arguments arrives during a run. A design that re-latched would change the row bytes, or would start a second run after the first.

// File: rtl/spinand_pe_pkg.sv
// Package: command codes, status bit positions and the state/frame types
// shared by the sequencer and its helpers.
package spinand_pe_pkg;

    localparam logic [7:0] OPC_CACHE_LOAD = 8'h02;
    localparam logic [7:0] OPC_WR_EN      = 8'h06;
    localparam logic [7:0] OPC_COMMIT     = 8'h10;
    localparam logic [7:0] OPC_BLK_ERASE  = 8'hD8;
    localparam logic [7:0] OPC_GET_REG    = 8'h0F;
    localparam logic [7:0] REG_STATUS     = 8'hC0;
    localparam logic [7:0] FILL_BYTE      = 8'h00;

    localparam int STS_BUSY_BIT  = 0;
    localparam int STS_EFAIL_BIT = 2;
    localparam int STS_PFAIL_BIT = 3;

    typedef enum logic [2:0] {
        FR_LOAD,
        FR_WREN,
        FR_COMMIT,
        FR_ERASE,
        FR_POLL
    } frame_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_GAP,
        ST_FIN
    } state_e;

endpackage

// File: rtl/spinand_pe_cmdgen.sv
// Byte selector: for the current frame and byte index, returns the byte to
// shift, whether it is a source data byte, and whether it ends the frame.
// Assumes the page is 2**PAGE_SHIFT bytes and a block is 2**BLK_SHIFT pages.
module spinand_pe_cmdgen
    import spinand_pe_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BLK_W      = 16,
    parameter int LEN_W      = 12,
    parameter int IDX_W      = 13,
    parameter int PAGE_SHIFT = 11,
    parameter int BLK_SHIFT  = 6
) (
    input  frame_e             frame_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [BLK_W-1:0]   blk_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic [7:0]         src_data_i,
    output logic [7:0]         byte_o,
    output logic               is_data_o,
    output logic               last_o
);
    localparam int HDR_BYTES = 3;

    logic [23:0]      row;
    logic [15:0]      col;
    logic [IDX_W-1:0] total;

    // Row and column fields derived from the latched arguments.
    always_comb begin
        col = 16'(addr_i[PAGE_SHIFT-1:0]);
        if (frame_i == FR_ERASE) row = 24'(blk_i) << BLK_SHIFT;
        else                     row = 24'(addr_i >> PAGE_SHIFT);
    end

    // Byte and frame-length selection per frame kind.
    always_comb begin
        byte_o    = FILL_BYTE;
        is_data_o = 1'b0;
        total     = IDX_W'(1);
        case (frame_i)
            FR_LOAD: begin
                total = IDX_W'(len_i) + IDX_W'(HDR_BYTES);
                if (idx_i == IDX_W'(0))      byte_o = OPC_CACHE_LOAD;
                else if (idx_i == IDX_W'(1)) byte_o = col[15:8];
                else if (idx_i == IDX_W'(2)) byte_o = col[7:0];
                else begin
                    byte_o    = src_data_i;
                    is_data_o = 1'b1;
                end
            end
            FR_WREN: byte_o = OPC_WR_EN;
            FR_COMMIT, FR_ERASE: begin
                total = IDX_W'(4);
                if (idx_i == IDX_W'(0))      byte_o = (frame_i == FR_ERASE) ? OPC_BLK_ERASE : OPC_COMMIT;
                else if (idx_i == IDX_W'(1)) byte_o = row[23:16];
                else if (idx_i == IDX_W'(2)) byte_o = row[15:8];
                else                         byte_o = row[7:0];
            end
            FR_POLL: begin
                total = IDX_W'(3);
                if (idx_i == IDX_W'(0))      byte_o = OPC_GET_REG;
                else if (idx_i == IDX_W'(1)) byte_o = REG_STATUS;
                else                         byte_o = FILL_BYTE;
            end
            default: byte_o = FILL_BYTE;
        endcase
        last_o = (idx_i == total - IDX_W'(1));
    end

endmodule

// File: rtl/spinand_pe_verdict.sv
// Verdict register: takes the status byte at the end of a status read,
// reports whether the device is still busy, and keeps the fail flag of the
// last finished operation. Assumes capture_i only fires on the status byte.
module spinand_pe_verdict
    import spinand_pe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       capture_i,
    input  logic       erase_i,
    input  logic [7:0] status_i,
    output logic       dev_busy_o,
    output logic       fail_o
);
    // Device still working when its busy bit reads 1.
    always_comb dev_busy_o = status_i[STS_BUSY_BIT];

    // Fail flag: cleared at start, loaded from the per-operation bit at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)                               fail_o <= 1'b0;
        else if (clear_i)                         fail_o <= 1'b0;
        else if (capture_i && !dev_busy_o)
            fail_o <= erase_i ? status_i[STS_EFAIL_BIT] : status_i[STS_PFAIL_BIT];
    end

    // R11
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !(capture_i && !dev_busy_o)) |=> $stable(fail_o));

endmodule

// File: rtl/spinand_pe_engine.sv
// Program/erase sequencer for a serial NAND device. Walks the frame list of
// the chosen operation (load, write enable, commit, poll; or write enable,
// erase, poll), one byte per shifter handshake, with a one-cycle chip-select
// gap between frames. Assumes spi_ack_i is only raised while spi_req_o is high.
module spinand_pe_engine
    import spinand_pe_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BLK_W      = 16,
    parameter int LEN_W      = 12,
    parameter int PAGE_SHIFT = 11,
    parameter int BLK_SHIFT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_erase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BLK_W-1:0]  blk_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [7:0]        src_data_i,
    input  logic              src_valid_i,
    output logic              src_ready_o,
    output logic              spi_cs_o,
    output logic              spi_req_o,
    output logic [7:0]        spi_tx_o,
    input  logic              spi_ack_i,
    input  logic [7:0]        spi_rx_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o
);
    localparam int IDX_W = LEN_W + 1;

    state_e            state_q;
    frame_e            frame_q;
    logic [IDX_W-1:0]  idx_q;
    logic              erase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BLK_W-1:0]  blk_q;
    logic [LEN_W-1:0]  len_q;

    logic accept, fire, is_data, last, capture, dev_busy;

    spinand_pe_cmdgen #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .LEN_W(LEN_W), .IDX_W(IDX_W),
        .PAGE_SHIFT(PAGE_SHIFT), .BLK_SHIFT(BLK_SHIFT)
    ) i_cmdgen (
        .frame_i(frame_q), .idx_i(idx_q), .addr_i(addr_q), .blk_i(blk_q),
        .len_i(len_q), .src_data_i(src_data_i), .byte_o(spi_tx_o),
        .is_data_o(is_data), .last_o(last)
    );

    spinand_pe_verdict i_verdict (
        .clk(clk), .rst_n(rst_n), .clear_i(accept), .capture_i(capture),
        .erase_i(erase_q), .status_i(spi_rx_i), .dev_busy_o(dev_busy),
        .fail_o(fail_o)
    );

    // Handshake and status decode for the current cycle.
    always_comb begin
        accept      = start_i && (state_q == ST_IDLE);
        spi_cs_o    = (state_q == ST_SEND);
        spi_req_o   = spi_cs_o && (!is_data || src_valid_i);
        fire        = spi_req_o && spi_ack_i;
        src_ready_o = spi_cs_o && is_data && spi_ack_i;
        capture     = fire && last && (frame_q == FR_POLL);
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_FIN);
    end

    // Argument latch: captured only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_q <= 1'b0;
            addr_q  <= '0;
            blk_q   <= '0;
            len_q   <= '0;
        end else if (accept) begin
            erase_q <= op_erase_i;
            addr_q  <= addr_i;
            blk_q   <= blk_i;
            len_q   <= len_i;
        end
    end

    // Sequencer: state, current frame and byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            frame_q <= FR_LOAD;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_SEND;
                    frame_q <= op_erase_i ? FR_WREN : FR_LOAD;
                    idx_q   <= '0;
                end
                ST_SEND: if (fire) begin
                    if (last) begin
                        idx_q   <= '0;
                        state_q <= (capture && !dev_busy) ? ST_FIN : ST_GAP;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_GAP: begin
                    state_q <= ST_SEND;
                    case (frame_q)
                        FR_LOAD: frame_q <= FR_WREN;
                        FR_WREN: frame_q <= erase_q ? FR_ERASE : FR_COMMIT;
                        default: frame_q <= FR_POLL;
                    endcase
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10
    req_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req_o |-> spi_cs_o);

    // R10
    frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && last) |=> !spi_cs_o);

    // R3
    ready_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready_o |-> (spi_ack_i && spi_cs_o && src_valid_i));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(erase_q) && $stable(addr_q) && $stable(blk_q)));

endmodule

// File: tb/test_spinand_pe_engine.sv
module test_spinand_pe_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_erase_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [15:0] blk_i = '0;
    logic [11:0] len_i = '0;
    logic [7:0]  src_data_i = '0;
    logic        src_valid_i = 1'b0;
    logic        src_ready_o;
    logic        spi_cs_o, spi_req_o;
    logic [7:0]  spi_tx_o;
    logic        spi_ack_i = 1'b0;
    logic [7:0]  spi_rx_i = '0;
    logic        busy_o, done_o, fail_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    spinand_pe_engine i_spinand_pe_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
        .addr_i(addr_i), .blk_i(blk_i), .len_i(len_i), .src_data_i(src_data_i),
        .src_valid_i(src_valid_i), .src_ready_o(src_ready_o), .spi_cs_o(spi_cs_o),
        .spi_req_o(spi_req_o), .spi_tx_o(spi_tx_o), .spi_ack_i(spi_ack_i),
        .spi_rx_i(spi_rx_i), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
    );

    int   n_chk = 0, n_fail = 0, cycles = 0;
    bit   timed_out = 0;
    bit   start_req = 0;
    logic [15:0] lfsr = 16'hACE1;
    int   srcq[$];
    int   mq[$];
    int   ms = 0;
    bit   mop = 0, mfail = 0;
    int   polls_left = 0;
    logic [7:0] stat_bits = '0;
    bit   saw_done = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push_poll();
        mq.push_back(8'h0F); mq.push_back(8'hC0); mq.push_back(8'h00); mq.push_back(-3);
    endtask

    task automatic build(input bit er, input logic [31:0] a, input logic [15:0] b,
                         input int n);
        int row;
        int col;
        mq.delete();
        if (!er) begin
            col = a % 2048;
            row = (a / 2048) % (1 << 24);
            mq.push_back(8'h02); mq.push_back(col / 256); mq.push_back(col % 256);
            for (int k = 0; k < n; k++) mq.push_back(-1);
            mq.push_back(-2);
            mq.push_back(8'h06); mq.push_back(-2);
            mq.push_back(8'h10);
        end else begin
            row = (b * 64) % (1 << 24);
            mq.push_back(8'h06); mq.push_back(-2);
            mq.push_back(8'hD8);
        end
        mq.push_back((row >> 16) % 256); mq.push_back((row >> 8) % 256);
        mq.push_back(row % 256); mq.push_back(-2);
        push_poll();
    endtask

    task automatic tick();
        logic [7:0] rxv;
        int  cur;
        bit  m_cs, m_data, m_req, m_ready;
        logic [7:0] m_tx;
        @(negedge clk);
        start_i   = start_req;
        start_req = 0;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        src_valid_i = (srcq.size() > 0) && (lfsr[0] | lfsr[5]);
        src_data_i  = (srcq.size() > 0) ? 8'(srcq[0]) : 8'h00;
        rxv = stat_bits | ((polls_left > 0) ? 8'h01 : 8'h00);
        spi_rx_i = rxv;
        #1;
        spi_ack_i = spi_req_o && (lfsr[1] | lfsr[2]);
        #1;
        cycles++;
        if (!rst_n) begin
            ms = 0; mfail = 0; mq.delete();
            return;
        end
        m_cs   = (ms == 1);
        cur    = m_cs ? mq[0] : 0;
        m_data = m_cs && (cur == -1);
        m_req  = m_cs && (!m_data || src_valid_i);
        m_tx   = m_data ? src_data_i : 8'(cur);
        m_ready = m_data && spi_ack_i;
        check(spi_cs_o == m_cs, "R10", "spi_cs_o", spi_cs_o, m_cs);
        check(spi_req_o == m_req, "R3", "spi_req_o", spi_req_o, m_req);
        if (m_req)
            check(spi_tx_o == m_tx, "R2/R4/R5/R6/R7", "spi_tx_o", spi_tx_o, m_tx);
        check(src_ready_o == m_ready, "R3", "src_ready_o", src_ready_o, m_ready);
        check(busy_o == (ms != 0), "R9", "busy_o", busy_o, ms != 0);
        check(done_o == (ms == 3), "R8", "done_o", done_o, ms == 3);
        check(fail_o == mfail, "R11", "fail_o", fail_o, mfail);
        if (done_o) saw_done = 1;
        case (ms)
            0: if (start_i) begin
                build(op_erase_i, addr_i, blk_i, int'(len_i));
                mop = op_erase_i; mfail = 0; ms = 1;
            end
            1: if (m_req && spi_ack_i) begin
                if (cur == -1) void'(srcq.pop_front());
                void'(mq.pop_front());
                if (mq[0] == -2) begin
                    void'(mq.pop_front()); ms = 2;
                end else if (mq[0] == -3) begin
                    void'(mq.pop_front());
                    if (rxv[0]) begin
                        polls_left--; push_poll(); ms = 2;
                    end else begin
                        mfail = mop ? rxv[2] : rxv[3]; ms = 3;
                    end
                end
            end
            2: ms = 1;
            default: ms = 0;
        endcase
    endtask

    task automatic wait_done();
        saw_done = 0;
        for (int k = 0; k < 5000 && !saw_done; k++) tick();
        if (!saw_done) begin
            timed_out = 1;
            check(0, "R8", "done never seen", 0, 1);
        end
    endtask

    task automatic run(input bit er, input logic [31:0] a, input logic [15:0] b,
                       input int n, input int polls, input logic [7:0] sb,
                       input bit intrude, input string tag);
        bit exp_fail;
        op_erase_i = er; addr_i = a; blk_i = b; len_i = 12'(n);
        for (int k = 0; k < n; k++) srcq.push_back((k * 37 + 11) % 256);
        polls_left = polls; stat_bits = sb;
        start_req = 1;
        tick();
        if (intrude) begin
            for (int k = 0; k < 6; k++) tick();
            op_erase_i = ~er; addr_i = 32'h00FF_F800; blk_i = 16'h0123; len_i = 12'd2;
            start_req = 1;
            tick();
        end
        wait_done();
        exp_fail = er ? sb[2] : sb[3];
        check(fail_o == exp_fail, tag, "verdict", fail_o, exp_fail);
        for (int k = 0; k < 3; k++) tick();
        check(busy_o == 1'b0, "R9", "idle after run", busy_o, 0);
        check(fail_o == exp_fail, "R11", "verdict held", fail_o, exp_fail);
        check(srcq.size() == 0, "R2", "source bytes consumed", srcq.size(), 0);
        srcq.delete();
    endtask

    initial begin
        for (int k = 0; k < 3; k++) tick();
        rst_n = 1'b1;
        tick();
        check(!spi_cs_o && !spi_req_o && !src_ready_o && !busy_o && !done_o && !fail_o,
              "R1", "reset outputs", {spi_cs_o, spi_req_o, src_ready_o, busy_o, done_o, fail_o}, 0);
        // R2 R5 R8: program, erase-fail bit set must not fail a program run
        run(0, 32'h0001_2345, 16'h0, 5, 2, 8'h04, 0, "R8");
        // R4 R6 R8: erase, program-fail bit set must not fail an erase run
        run(1, 32'h0, 16'h02A5, 0, 1, 8'h08, 0, "R8");
        // R6 R8: erase reporting a failure
        run(1, 32'h0, 16'h0003, 0, 0, 8'h04, 0, "R8");
        // R11: the next start clears the previous fail; R9: start while busy ignored
        run(0, 32'h0000_0800, 16'h0, 7, 3, 8'h08, 1, "R9");
        // R2 R7: last column of a page, one byte, many polls
        run(0, 32'h0003_07FF, 16'h0, 1, 4, 8'h00, 0, "R7");
        // R3: longer burst with source stalls
        run(0, 32'h00AB_C010, 16'h0, 20, 1, 8'h00, 0, "R3");
        if (timed_out) $display("watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule